// File: doc/BRIEF.md
# SIMD Immediate Shift-Left Unit

This unit takes one 32-bit instruction word and a 128-bit source vector per transfer. It checks whether the word is the vector or the scalar form of a shift-left-by-immediate instruction. From the immediate bits it works out the element size and the shift amount. Each element of the source is shifted left on its own: no bit moves into a neighbouring element, and the vacated low bits become zero. The result vector, the destination register index, a match flag and an undefined-encoding flag are returned one cycle later through a single output register.

Both ends use a valid/ready handshake. A word is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stalled consumer stalls the producer. While `out_valid` is high and `out_ready` is low, every output holds its value. The unit only classifies words against the two shift-left patterns. A word that matches neither leaves the unit with the match flag low and an all-zero result. Condition flags are never involved.

Top module: `simd_shl_unit`

## Requirements
- R1: A word with bit 31 = 0, bit 29 = 0, bits 28:23 = 011110, bits 15:10 = 010101 and a nonzero 4-bit field at bits 22:19 is a vector match. `res_hit` is 1 for it in the output cycle. Bit 30 is the width select.
- R2: A word with bits 31:29 = 010, bits 28:23 = 111110, bits 15:10 = 010101 and a nonzero field at bits 22:19 is a scalar match, and `res_hit` is 1.
- R3: Any other word, including one whose bits 22:19 are 0000, gives `res_hit` = 0, `res_undef` = 0 and `res_data` = 0.
- R4: The highest set bit of bits 22:19 gives the element size: bit 19 gives 8, bit 20 gives 16, bit 21 gives 32 and bit 22 gives 64. The shift amount is the unsigned value of bits 22:16 minus the element size.
- R5: With bit 30 = 1, each element of all 128 bits is shifted left by the shift amount. Zeros fill the low end, and bits shifted past an element's top are dropped.
- R6: With bit 30 = 0 in the vector form, only the low 64 bits are shifted, and `res_data[127:64]` is zero.
- R7: A vector word whose bits 22:19 are 1xxx and whose bit 30 is 0 raises `res_undef`, and `res_data` is zero.
- R8: The scalar form is legal only when bit 22 = 1. It then shifts one 64-bit element in the low half, and the upper 64 bits are zero. With bit 22 = 0 it raises `res_undef`, and `res_data` is zero.
- R9: `res_rd` equals bits 4:0 of the accepted word.
- R10: `in_ready` = !`out_valid` || `out_ready`. An accepted word makes `out_valid` high on the next edge. While `out_valid` is high and `out_ready` is low, all outputs hold.
- R11: A synchronous reset, `rst` high on a clock edge, clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction and source are offered |
| in_ready | output | 1 | Unit can take a word this cycle |
| instr | input | 32 | Instruction word |
| src_vec | input | 128 | Source vector |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| res_hit | output | 1 | Word matched a shift-left pattern |
| res_undef | output | 1 | Matched but reserved encoding |
| res_rd | output | 5 | Destination register index |
| res_data | output | 128 | Shifted result vector |

## Verification
Directed words cover each element size with extra low immediate bits set. This separates a decoder that reads the highest set bit from one that reads any set bit, and it exposes an off-by-one in the shift subtraction. Source patterns with ones near element boundaries show any leak of bits across lanes. Half-width vector words and scalar words with rich upper-half sources tell the width masking apart. Near-miss words with one fixed bit flipped, and words with an empty immediate field, separate a real match from a loose one. Random stretches of valid and ready show whether a stalled output holds and whether a word is lost or duplicated.

// File: rtl/simd_shl_pkg.sv
package simd_shl_pkg;

  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esz_e;

  localparam int unsigned INSTR_W = 32;
  localparam int unsigned RD_W    = 5;
  localparam int unsigned IMM7_W  = 7;

  typedef struct packed {
    logic              hit;
    logic              undef;
    logic              full;
    esz_e              esz;
    logic [IMM7_W-1:0] shamt;
    logic [RD_W-1:0]   rd;
  } shl_dec_t;

endpackage

// File: rtl/simd_shl_decode.sv
module simd_shl_decode
  import simd_shl_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output shl_dec_t           dec
);

  logic [3:0]        sel_h;
  logic [2:0]        sel_l;
  logic              common_ok;
  logic              is_vec;
  logic              is_sca;
  logic [IMM7_W-1:0] imm7;
  logic [IMM7_W-1:0] lane_bits;
  logic              unused_rn_bits;

  assign sel_h          = instr[22:19];
  assign sel_l          = instr[18:16];
  assign imm7           = {sel_h, sel_l};
  assign unused_rn_bits = ^instr[9:5];

  always_comb begin
    common_ok = (instr[29] == 1'b0) && (instr[15:10] == 6'b010101) && (sel_h != 4'b0000);
    is_vec    = common_ok && (instr[31] == 1'b0) && (instr[28:23] == 6'b011110);
    is_sca    = common_ok && (instr[31:30] == 2'b01) && (instr[28:23] == 6'b111110);

    casez (sel_h)
      4'b1???: dec.esz = ESZ_64;
      4'b01??: dec.esz = ESZ_32;
      4'b001?: dec.esz = ESZ_16;
      default: dec.esz = ESZ_8;
    endcase

    lane_bits = IMM7_W'(8) << dec.esz;
    dec.shamt = imm7 - lane_bits;
    dec.hit   = is_vec || is_sca;
    dec.undef = (is_vec && sel_h[3] && !instr[30]) || (is_sca && !sel_h[3]);
    dec.full  = is_vec && instr[30];
    dec.rd    = instr[RD_W-1:0];
  end

  // R4: a legal match always yields a shift below the element width
  always_comb begin
    if (dec.hit && !dec.undef) begin
      p_shamt_range_r4: assert (dec.shamt < (IMM7_W'(8) << dec.esz))
        else $error("p_shamt_range_r4 shift %0d out of range", dec.shamt);
    end
  end

endmodule

// File: rtl/simd_shl_lanes.sv
module simd_shl_lanes
  import simd_shl_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic [VEC_W-1:0]  src,
  input  esz_e              esz,
  input  logic [IMM7_W-1:0] shamt,
  output logic [VEC_W-1:0]  shifted
);

  localparam int unsigned N_SIZES = 4;

  logic [N_SIZES-1:0][VEC_W-1:0] by_size;

  for (genvar s = 0; s < N_SIZES; s++) begin : g_size
    localparam int unsigned LW = 8 << s;
    localparam int unsigned NL = VEC_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      assign by_size[s][l*LW +: LW] =
        (int'(shamt) >= LW) ? '0 : (src[l*LW +: LW] << shamt);
    end
  end

  assign shifted = by_size[esz];

endmodule

// File: rtl/simd_shl_unit.sv
module simd_shl_unit
  import simd_shl_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [INSTR_W-1:0] instr,
  input  logic [VEC_W-1:0]   src_vec,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               res_hit,
  output logic               res_undef,
  output logic [RD_W-1:0]    res_rd,
  output logic [VEC_W-1:0]   res_data
);

  localparam int unsigned HALF_W = VEC_W / 2;

  shl_dec_t         dec;
  logic [VEC_W-1:0] shifted;
  logic [VEC_W-1:0] data_nxt;
  logic             take;

  simd_shl_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  simd_shl_lanes #(.VEC_W(VEC_W)) u_lanes (
    .src     (src_vec),
    .esz     (dec.esz),
    .shamt   (dec.shamt),
    .shifted (shifted)
  );

  always_comb begin
    if (!dec.hit || dec.undef) begin
      data_nxt = '0;
    end else begin
      data_nxt = {dec.full ? shifted[VEC_W-1:HALF_W] : {HALF_W{1'b0}},
                  shifted[HALF_W-1:0]};
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      res_hit   <= dec.hit;
      res_undef <= dec.undef;
      res_rd    <= dec.rd;
      res_data  <= data_nxt;
    end
  end

  p_accept_r10: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid)
    else $error("p_accept_r10");

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(res_data) && $stable(res_rd)
                                   && $stable(res_hit) && $stable(res_undef)))
    else $error("p_hold_r10");

  p_undef_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && res_undef) |-> (res_hit && res_data == '0))
    else $error("p_undef_zero_r7");

  p_nohit_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !res_hit) |-> (!res_undef && res_data == '0))
    else $error("p_nohit_quiet_r3");

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> !out_valid)
    else $error("p_reset_clear_r11");

endmodule

// File: tb/simd_shl_unit_tb.sv
module simd_shl_unit_tb;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  instr = '0;
  logic [127:0] src_vec = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic         res_hit;
  logic         res_undef;
  logic [4:0]   res_rd;
  logic [127:0] res_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state: one-deep output register
  bit           m_valid = 0;
  bit           m_hit;
  bit           m_undef;
  bit [4:0]     m_rd;
  bit [127:0]   m_data;
  string        m_tag = "R5";

  always #2 clk = ~clk;

  simd_shl_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .src_vec(src_vec), .out_valid(out_valid), .out_ready(out_ready),
    .res_hit(res_hit), .res_undef(res_undef), .res_rd(res_rd), .res_data(res_data)
  );

  function automatic bit [31:0] enc_vec(bit q, bit [3:0] h, bit [2:0] l, bit [4:0] rn, bit [4:0] rd);
    return {1'b0, q, 1'b0, 6'b011110, h, l, 6'b010101, rn, rd};
  endfunction

  function automatic bit [31:0] enc_sca(bit [3:0] h, bit [2:0] l, bit [4:0] rn, bit [4:0] rd);
    return {2'b01, 1'b0, 6'b111110, h, l, 6'b010101, rn, rd};
  endfunction

  function automatic void ref_shl(input bit [31:0] w, input bit [127:0] s,
                                  output bit hit, output bit und, output bit [127:0] d);
    bit vec, sca;
    int es, sh, nl;
    vec = (w[31] == 0) && (w[29] == 0) && (w[28:23] == 6'b011110) &&
          (w[15:10] == 6'b010101) && (w[22:19] != 0);
    sca = (w[31:30] == 2'b01) && (w[29] == 0) && (w[28:23] == 6'b111110) &&
          (w[15:10] == 6'b010101) && (w[22:19] != 0);
    es = 8;
    for (int k = 0; k < 4; k++) if (w[19+k]) es = 8 << k;
    sh  = int'(w[22:16]) - es;
    nl  = sca ? 1 : (w[30] ? 128 / es : 64 / es);
    hit = vec || sca;
    und = (vec && w[22] && !w[30]) || (sca && !w[22]);
    d   = '0;
    if (hit && !und) begin
      for (int b = 0; b < 128; b++) begin
        if ((b / es) < nl && (b % es) >= sh) d[b] = s[b - sh];
      end
    end
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // called at a falling edge; drives one cycle of stimulus
  task automatic step(bit [31:0] w, bit [127:0] s, bit v, bit r, string tag);
    bit exp_rdy, h, u;
    bit [127:0] d;
    chk(out_valid === m_valid, "R10 R11", "out_valid", 128'(out_valid), 128'(m_valid));
    if (m_valid && out_valid === 1'b1) begin
      chk(res_hit === m_hit, "R1 R2 R3", "res_hit", 128'(res_hit), 128'(m_hit));
      chk(res_undef === m_undef, "R7 R8", "res_undef", 128'(res_undef), 128'(m_undef));
      chk(res_rd === m_rd, "R9", "res_rd", 128'(res_rd), 128'(m_rd));
      chk(res_data === m_data, m_tag, "res_data", res_data, m_data);
    end
    instr = w; src_vec = s; in_valid = v; out_ready = r;
    #1;
    exp_rdy = !m_valid || r;
    chk(in_ready === exp_rdy, "R10", "in_ready", 128'(in_ready), 128'(exp_rdy));
    if (v && exp_rdy) begin
      ref_shl(w, s, h, u, d);
      m_valid = 1; m_hit = h; m_undef = u; m_rd = w[4:0]; m_data = d; m_tag = tag;
    end else if (r) begin
      m_valid = 0;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(bit [31:0] w, bit [127:0] s, string tag);
    step(w, s, 1'b1, 1'b1, tag);
  endtask

  localparam bit [127:0] PAT_A = 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F;
  localparam bit [127:0] PAT_B = 128'h8001_8001_FFFF_0001_8000_7FFF_0180_FF01;
  localparam bit [127:0] ONES  = '1;

  initial begin
    @(negedge clk);
    // R11: reset state
    for (int i = 0; i < 3; i++) begin
      chk(out_valid === 1'b0, "R11", "out_valid in reset", 128'(out_valid), 128'd0);
      @(negedge clk);
    end
    rst = 1'b0;

    // R1 R5: full vector, byte lanes, shift 3
    push(enc_vec(1, 4'b0001, 3'd3, 5'd2, 5'd7), ONES, "R5");
    push(enc_vec(1, 4'b0001, 3'd7, 5'd1, 5'd1), PAT_A, "R5");
    push(enc_vec(1, 4'b0001, 3'd0, 5'd1, 5'd31), PAT_B, "R5");
    // R4: extra low immh bits set, every size
    push(enc_vec(1, 4'b0011, 3'd5, 5'd0, 5'd3), PAT_A, "R4");
    push(enc_vec(1, 4'b0111, 3'd1, 5'd0, 5'd4), PAT_B, "R4");
    push(enc_vec(1, 4'b1111, 3'd7, 5'd0, 5'd5), PAT_A, "R4");
    push(enc_vec(1, 4'b0101, 3'd2, 5'd0, 5'd6), ONES, "R4");
    push(enc_vec(1, 4'b1000, 3'd0, 5'd0, 5'd8), PAT_B, "R4");
    // R6: half width vectors
    push(enc_vec(0, 4'b0001, 3'd4, 5'd0, 5'd9), ONES, "R6");
    push(enc_vec(0, 4'b0010, 3'd6, 5'd0, 5'd10), PAT_A, "R6");
    push(enc_vec(0, 4'b0100, 3'd3, 5'd0, 5'd11), PAT_B, "R6");
    // R7: reserved half-width 64-bit form
    push(enc_vec(0, 4'b1010, 3'd1, 5'd0, 5'd12), ONES, "R7");
    // R2 R8: scalar forms
    push(enc_sca(4'b1000, 3'd4, 5'd0, 5'd13), ONES, "R8");
    push(enc_sca(4'b1110, 3'd7, 5'd0, 5'd14), PAT_A, "R8");
    push(enc_sca(4'b0100, 3'd0, 5'd0, 5'd15), ONES, "R8");
    push(enc_sca(4'b0001, 3'd2, 5'd0, 5'd16), ONES, "R8");
    // R3: non-matching words
    push(enc_vec(1, 4'b0000, 3'd5, 5'd0, 5'd17), ONES, "R3");
    push(enc_sca(4'b0000, 3'd5, 5'd0, 5'd18), ONES, "R3");
    push(enc_vec(1, 4'b0001, 3'd1, 5'd0, 5'd19) ^ 32'h0000_0400, ONES, "R3");
    push(enc_vec(1, 4'b0001, 3'd1, 5'd0, 5'd20) ^ 32'h2000_0000, ONES, "R3");
    push(enc_vec(1, 4'b0001, 3'd1, 5'd0, 5'd21) ^ 32'h8000_0000, ONES, "R3");
    push(enc_sca(4'b1000, 3'd1, 5'd0, 5'd22) ^ 32'h0080_0000, ONES, "R3");
    push(32'hFFFF_FFFF, ONES, "R3");
    // R10: stall with new offers pending
    push(enc_vec(1, 4'b0010, 3'd1, 5'd0, 5'd23), PAT_A, "R10");
    for (int i = 0; i < 4; i++)
      step(enc_vec(1, 4'b0001, 3'(i), 5'd0, 5'(i)), PAT_B, 1'b1, 1'b0, "R10");
    step('0, '0, 1'b0, 1'b1, "R10");
    step('0, '0, 1'b0, 1'b1, "R10");

    // randomised traffic
    for (int i = 0; i < 3000; i++) begin
      bit [31:0] w;
      bit [127:0] s;
      int sel;
      sel = $urandom_range(0, 9);
      s = {$urandom, $urandom, $urandom, $urandom};
      if (sel < 5)      w = enc_vec(1'($urandom), 4'($urandom), 3'($urandom), 5'($urandom), 5'($urandom));
      else if (sel < 8) w = enc_sca(4'($urandom), 3'($urandom), 5'($urandom), 5'($urandom));
      else              w = $urandom;
      step(w, s, 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0), "R5");
    end

    // R11: reset with a result pending
    step(enc_vec(1, 4'b0001, 3'd2, 5'd0, 5'd1), ONES, 1'b1, 1'b0, "R11");
    in_valid = 1'b0; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(out_valid === 1'b0, "R11", "out_valid after reset", 128'(out_valid), 128'd0);
    rst = 1'b0; m_valid = 0;
    step('0, '0, 1'b0, 1'b1, "R11");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule